// File: doc/BRIEF.md
# SDRAM Data-Path Latency Pipeline

This block is the data side of an SDRAM interface. Each clock it learns from the command decoder whether a read or a write command was issued, and from the column address generator whether a further beat of the current burst is due. For a read beat it captures the word coming from the storage array and holds it in a delay line for the programmed CAS latency of two or three clocks. It then presents the word on the data output together with a per-byte-lane output enable. For a write beat it captures the word on the data input in the same cycle as the command, together with a byte-lane enable formed from the data mask.

The data mask acts differently in the two directions. On a write it drops byte lanes of the word captured in the same cycle. On a read it blanks the output drive of byte lanes two clocks after it is raised. A precharge ends the current burst, so the data slots it would have filled are released from the bus after the CAS latency. A write command throws away every read word still in the delay line, which keeps the interface from driving stale read data after the bus has turned around.

Top module: `sdram_dpath_pipe`

## Requirements
- R1: A read beat in cycle n gives `rdValid` high in cycle n+2 when `cl3` is 0, or in cycle n+3 when `cl3` is 1, with `dqOut` equal to the `arrData` presented in cycle n.
- R2: A read command issued while a read burst is in flight adds its own beat to the delay line, and consecutive beats leave the output with no empty slot between them.
- R3: Bit i of `dqm` raised in cycle m clears `dqOe[i]` in cycle m+2. Lane i covers `dqOut[8i+7:8i]`. `rdValid` is not affected by the mask.
- R4: In any cycle without a read slot, `dqOe` is all zero and `dqOut` is zero.
- R5: A write beat (the cycle of a write command, or a later cycle of a write burst with `burstValid` high) gives `wrValid` high in the next cycle, with `wrData` equal to the `dqIn` of the beat cycle.
- R6: `wrByteEn` is the inverse of the `dqm` of the write-beat cycle, so a beat with every mask bit high is still reported with a byte enable of zero.
- R7: A precharge in cycle p drops any beat of that cycle. `burstValid` is then ignored until the next read or write command, so the output holds no slot from cycle p+2 (`cl3`=0) or p+3 (`cl3`=1) onward.
- R8: A write command in cycle n discards all read words still in the delay line, so no read slot appears from cycle n+1 until a new read delivers.
- R9: When commands coincide, precharge wins over write and write wins over read. The losing command produces no beat.
- R10: While `rstN` is low all outputs are zero. After release, no slot appears that was not started by a beat after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cl3 | input | 1 | CAS latency select: 0 for two clocks, 1 for three |
| cmdRead | input | 1 | Read command this cycle (first beat of a read burst) |
| cmdWrite | input | 1 | Write command this cycle (first beat of a write burst) |
| cmdPrecharge | input | 1 | Precharge command this cycle, ends the burst |
| burstValid | input | 1 | A further burst beat is due this cycle |
| dqm | input | DW/LANE_W | Per-byte-lane data mask |
| dqIn | input | DW | Write data from the bus |
| arrData | input | DW | Read data from the storage array |
| dqOut | output | DW | Read data to the bus |
| dqOe | output | DW/LANE_W | Per-byte-lane output enable |
| rdValid | output | 1 | A read slot occupies this cycle |
| wrData | output | DW | Captured write data |
| wrByteEn | output | DW/LANE_W | Byte enables of the captured write |
| wrValid | output | 1 | Captured write beat is valid |

## Verification
The main sweep runs read bursts at both latencies and checks each data tag for the exact slot cycle, which separates a two-clock tap from a three-clock tap and exposes any gap when a second read command lands inside a burst. Read masks and write masks are raised at different points of bursts: a partial mask on a read shows the two-clock mask delay, and a partial mask on a write shows the zero delay and the lane ordering. Precharge is placed in the middle of bursts at each latency to pin the cycle in which the bus is released. A write is placed behind in-flight reads to show that they are discarded, and coinciding commands show the priority order. A reset applied with reads in flight shows that the outputs clear at once.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  // Per-cycle strobes handed from the control decoder to the datapath.
  typedef struct packed {
    logic rdBeat;  // a read word enters the latency line this cycle
    logic wrBeat;  // a write word is captured this cycle
    logic flush;   // drop all read words still in flight
  } sdp_strobe_t;

  typedef enum logic [1:0] {
    DIR_IDLE  = 2'd0,
    DIR_READ  = 2'd1,
    DIR_WRITE = 2'd2
  } sdp_dir_e;

endpackage

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
  import sdp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdRead,
  input  logic        cmdWrite,
  input  logic        cmdPrecharge,
  input  logic        burstValid,
  output sdp_strobe_t strobe
);

  sdp_dir_e dirQ;
  sdp_dir_e dirD;

  // Command decode: precharge over write over read; burst beats follow
  // the direction set by the last command.
  always_comb begin
    strobe = '0;
    dirD   = dirQ;
    if (cmdPrecharge) begin
      dirD = DIR_IDLE;
    end else if (cmdWrite) begin
      strobe.wrBeat = 1'b1;
      strobe.flush  = 1'b1;
      dirD          = DIR_WRITE;
    end else if (cmdRead) begin
      strobe.rdBeat = 1'b1;
      dirD          = DIR_READ;
    end else if (burstValid) begin
      strobe.rdBeat = (dirQ == DIR_READ);
      strobe.wrBeat = (dirQ == DIR_WRITE);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirQ <= DIR_IDLE;
    else       dirQ <= dirD;
  end

  AST_PRE_STOPS_BURST: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cmdPrecharge) && !cmdRead && !cmdWrite) |-> (!strobe.rdBeat && !strobe.wrBeat)); // R7

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !cmdPrecharge) |-> (strobe.wrBeat && !strobe.rdBeat)); // R9

  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdBeat && strobe.wrBeat)); // R9

endmodule

// File: rtl/sdp_datapath.sv
module sdp_datapath
  import sdp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int LANE_W   = 8,
  parameter int LO_CL    = 2,
  parameter int HI_CL    = 3,
  parameter int MASK_LAT = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  sdp_strobe_t              strobe,
  input  logic                     cl3,
  input  logic [DW/LANE_W-1:0]     dqm,
  input  logic [DW-1:0]            dqIn,
  input  logic [DW-1:0]            arrData,
  output logic [DW-1:0]            dqOut,
  output logic [DW/LANE_W-1:0]     dqOe,
  output logic                     rdValid,
  output logic [DW-1:0]            wrData,
  output logic [DW/LANE_W-1:0]     wrByteEn,
  output logic                     wrValid
);

  localparam int LANES  = DW / LANE_W;
  localparam int DEPTH  = HI_CL;

  // Read latency line: entry k holds the word that is k+1 clocks old.
  logic [DEPTH-1:0] stValid;
  logic [DW-1:0]    stData [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stValid <= '0;
      for (int k = 0; k < DEPTH; k++) stData[k] <= '0;
    end else begin
      stValid[0] <= strobe.rdBeat;
      stData[0]  <= strobe.rdBeat ? arrData : '0;
      for (int k = 1; k < DEPTH; k++) begin
        stValid[k] <= stValid[k-1] & ~strobe.flush;
        stData[k]  <= stData[k-1];
      end
    end
  end

  // Read mask delay line.
  logic [LANES-1:0] maskPipe [MASK_LAT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < MASK_LAT; k++) maskPipe[k] <= '0;
    end else begin
      maskPipe[0] <= dqm;
      for (int k = 1; k < MASK_LAT; k++) maskPipe[k] <= maskPipe[k-1];
    end
  end

  // Tap selection by latency setting.
  logic          tapValid;
  logic [DW-1:0] tapData;

  always_comb begin
    if (cl3) begin
      tapValid = stValid[HI_CL-1];
      tapData  = stData[HI_CL-1];
    end else begin
      tapValid = stValid[LO_CL-1];
      tapData  = stData[LO_CL-1];
    end
  end

  assign rdValid = tapValid;
  assign dqOut   = tapValid ? tapData : '0;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane_oe
    assign dqOe[ln] = tapValid & ~maskPipe[MASK_LAT-1][ln];
  end

  // Write capture, mask applied in the beat cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid  <= 1'b0;
      wrData   <= '0;
      wrByteEn <= '0;
    end else begin
      wrValid  <= strobe.wrBeat;
      wrData   <= strobe.wrBeat ? dqIn : '0;
      wrByteEn <= strobe.wrBeat ? ~dqm : '0;
    end
  end

  // Cycles since reset, saturating, so history checks never reach before it.
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  AST_RD_LAT_HI: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && cl3 && rdValid) |-> $past(strobe.rdBeat, 3)); // R1

  AST_RD_LAT_LO: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2 && !cl3 && rdValid) |-> $past(strobe.rdBeat, 2)); // R1

  AST_RD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2) |-> (($past(dqm, 2) & dqOe) == '0)); // R3

  AST_OE_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (dqOe != '0) |-> rdValid); // R4

  AST_WR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd1 && wrValid) |-> (wrByteEn == ~$past(dqm))); // R6

  AST_WR_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd1 && $past(strobe.flush)) |-> !rdValid); // R8

endmodule

// File: rtl/sdram_dpath_pipe.sv
module sdram_dpath_pipe
  import sdp_pkg::*;
#(
  parameter int DW     = 16,
  parameter int LANE_W = 8,
  localparam int LANES = DW / LANE_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cl3,
  input  logic             cmdRead,
  input  logic             cmdWrite,
  input  logic             cmdPrecharge,
  input  logic             burstValid,
  input  logic [LANES-1:0] dqm,
  input  logic [DW-1:0]    dqIn,
  input  logic [DW-1:0]    arrData,
  output logic [DW-1:0]    dqOut,
  output logic [LANES-1:0] dqOe,
  output logic             rdValid,
  output logic [DW-1:0]    wrData,
  output logic [LANES-1:0] wrByteEn,
  output logic             wrValid
);

  sdp_strobe_t strobe;

  sdp_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdRead      (cmdRead),
    .cmdWrite     (cmdWrite),
    .cmdPrecharge (cmdPrecharge),
    .burstValid   (burstValid),
    .strobe       (strobe)
  );

  sdp_datapath #(
    .DW     (DW),
    .LANE_W (LANE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cl3      (cl3),
    .dqm      (dqm),
    .dqIn     (dqIn),
    .arrData  (arrData),
    .dqOut    (dqOut),
    .dqOe     (dqOe),
    .rdValid  (rdValid),
    .wrData   (wrData),
    .wrByteEn (wrByteEn),
    .wrValid  (wrValid)
  );

endmodule

// File: tb/sim_sdram_dpath_pipe.sv
module sim_sdram_dpath_pipe;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cl3 = 1'b0;
  logic        cmdRead = 1'b0, cmdWrite = 1'b0, cmdPrecharge = 1'b0, burstValid = 1'b0;
  logic [1:0]  dqm = 2'b00;
  logic [15:0] dqIn = '0, arrData = '0;
  logic [15:0] dqOut, wrData;
  logic [1:0]  dqOe, wrByteEn;
  logic        rdValid, wrValid;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  sdram_dpath_pipe u0 (
    .clk(clk), .rstN(rstN), .cl3(cl3), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .cmdPrecharge(cmdPrecharge), .burstValid(burstValid), .dqm(dqm), .dqIn(dqIn),
    .arrData(arrData), .dqOut(dqOut), .dqOe(dqOe), .rdValid(rdValid),
    .wrData(wrData), .wrByteEn(wrByteEn), .wrValid(wrValid)
  );

  typedef struct packed {
    logic       rd, wr, pre, c3, bv;
    logic [1:0] m;
    logic       eRv;
    logic [1:0] eOe;
    logic       eWv;
    logic [1:0] eBe;
    logic [7:0] tag;  // row whose arrData must appear when eRv
  } vec_t;

  localparam int NV = 29;
  // Row j: inputs of cycle j, expected outputs seen during cycle j.
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,0,2'b00, 0,2'b00, 0,2'b00, 0},   // 0 read, latency 2
    '{0,0,0,0,1,2'b00, 0,2'b00, 0,2'b00, 0},   // 1
    '{0,0,0,0,1,2'b01, 1,2'b11, 0,2'b00, 0},   // 2 R1 slot of row 0
    '{0,0,0,0,1,2'b00, 1,2'b11, 0,2'b00, 1},   // 3
    '{0,0,1,0,1,2'b00, 1,2'b10, 0,2'b00, 2},   // 4 R3 lane0 blanked; precharge
    '{0,0,0,0,1,2'b00, 1,2'b11, 0,2'b00, 3},   // 5
    '{0,0,0,0,0,2'b00, 0,2'b00, 0,2'b00, 0},   // 6 R7 released at p+2
    '{0,1,0,0,0,2'b10, 0,2'b00, 0,2'b00, 0},   // 7 R7 beat after precharge ignored; write
    '{0,0,0,0,1,2'b00, 0,2'b00, 1,2'b01, 0},   // 8 R6 partial write mask
    '{0,0,0,0,0,2'b00, 0,2'b00, 1,2'b11, 0},   // 9 R5 burst beat
    '{0,0,0,0,0,2'b00, 0,2'b00, 0,2'b00, 0},   // 10
    '{1,0,0,1,0,2'b00, 0,2'b00, 0,2'b00, 0},   // 11 read, latency 3
    '{0,0,0,1,1,2'b00, 0,2'b00, 0,2'b00, 0},   // 12
    '{1,0,0,1,0,2'b00, 0,2'b00, 0,2'b00, 0},   // 13 R2 read inside burst
    '{0,0,0,1,1,2'b00, 1,2'b11, 0,2'b00, 11},  // 14 R1
    '{0,0,0,1,0,2'b00, 1,2'b11, 0,2'b00, 12},  // 15 R2
    '{0,1,0,1,0,2'b00, 1,2'b11, 0,2'b00, 13},  // 16 R2 no gap; write command
    '{0,0,0,1,0,2'b00, 0,2'b00, 1,2'b11, 0},   // 17 R8 row 14 discarded
    '{1,0,0,1,0,2'b00, 0,2'b00, 0,2'b00, 0},   // 18
    '{0,0,0,1,0,2'b11, 0,2'b00, 0,2'b00, 0},   // 19
    '{0,0,0,1,0,2'b00, 0,2'b00, 0,2'b00, 0},   // 20
    '{0,0,0,1,0,2'b00, 1,2'b00, 0,2'b00, 18},  // 21 R3 both lanes blanked
    '{1,0,0,1,0,2'b00, 0,2'b00, 0,2'b00, 0},   // 22
    '{0,0,0,1,1,2'b00, 0,2'b00, 0,2'b00, 0},   // 23
    '{0,0,1,1,1,2'b00, 0,2'b00, 0,2'b00, 0},   // 24 precharge
    '{0,0,0,1,1,2'b00, 1,2'b11, 0,2'b00, 22},  // 25
    '{0,0,0,1,0,2'b00, 1,2'b11, 0,2'b00, 23},  // 26
    '{0,0,0,1,0,2'b00, 0,2'b00, 0,2'b00, 0},   // 27 R7 released at p+3
    '{0,0,0,1,0,2'b00, 0,2'b00, 0,2'b00, 0}    // 28
  };

  task automatic chk(input string tag, input int row, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s step %0d: actual %0h expected %0h", tag, row, act, exp);
    end
  endtask

  task automatic setIn(input logic rd, input logic wr, input logic pre, input logic bv,
                       input logic [1:0] m, input logic [15:0] d);
    cmdRead = rd; cmdWrite = wr; cmdPrecharge = pre; burstValid = bv; dqm = m; dqIn = d;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog: actual %0d cycles expected fewer", 200000);
    summary();
    $finish;
  end

  initial begin
    // R10: reset with read and burst requests driven
    setIn(1, 0, 0, 1, 2'b00, 16'h1111);
    repeat (3) @(negedge clk);
    chk("R10 rdValid in reset", 0, rdValid, 0);
    chk("R10 dqOe in reset", 0, dqOe, 0);
    chk("R10 wrValid in reset", 0, wrValid, 0);
    setIn(0, 0, 0, 0, 2'b00, 16'h0);
    rstN = 1'b1;

    // Table sweep
    for (int j = 0; j < NV; j++) begin
      @(negedge clk);
      chk("R1 rdValid", j, rdValid, VEC[j].eRv);
      chk("R3 dqOe", j, dqOe, VEC[j].eOe);
      chk("R5 wrValid", j, wrValid, VEC[j].eWv);
      if (VEC[j].eWv) begin
        chk("R6 wrByteEn", j, wrByteEn, VEC[j].eBe);
        chk("R5 wrData", j, wrData, 16'hB000 | 16'(j - 1));
      end
      if (VEC[j].eRv) chk("R1 dqOut", j, dqOut, 16'hA000 | 16'(VEC[j].tag));
      else            chk("R4 dqOut idle", j, dqOut, 16'h0);
      cl3 = VEC[j].c3;
      setIn(VEC[j].rd, VEC[j].wr, VEC[j].pre, VEC[j].bv, VEC[j].m, 16'hB000 | 16'(j));
      arrData = 16'hA000 | 16'(j);
    end

    // R9: read and write together, then read and precharge together (latency 2)
    @(negedge clk);
    cl3 = 1'b0;
    setIn(1, 1, 0, 0, 2'b00, 16'hC1C1);
    @(negedge clk);
    chk("R9 write wins wrValid", 100, wrValid, 1);
    chk("R5 wrData same cycle", 100, wrData, 16'hC1C1);
    setIn(0, 0, 0, 0, 2'b00, 16'h0);
    @(negedge clk);
    chk("R9 read lost to write", 101, rdValid, 0);
    setIn(1, 0, 1, 0, 2'b00, 16'h0);
    @(negedge clk);
    chk("R9 precharge wins wrValid", 102, wrValid, 0);
    setIn(0, 0, 0, 0, 2'b00, 16'h0);
    @(negedge clk);
    chk("R9 read lost to precharge", 103, rdValid, 0);
    chk("R4 dqOe idle", 103, dqOe, 0);

    // R6: fully masked write beat
    setIn(0, 1, 0, 0, 2'b11, 16'hD2D2);
    @(negedge clk);
    chk("R6 masked beat wrValid", 104, wrValid, 1);
    chk("R6 masked beat wrByteEn", 104, wrByteEn, 2'b00);
    setIn(0, 0, 0, 0, 2'b00, 16'h0);

    // R10: asynchronous reset with a read in flight
    @(negedge clk);
    arrData = 16'hE3E3;
    setIn(1, 0, 0, 0, 2'b00, 16'h0);
    @(negedge clk);
    setIn(0, 0, 0, 0, 2'b00, 16'h0);
    @(posedge clk);
    #2 rstN = 1'b0;
    #1;
    chk("R10 rdValid after async reset", 105, rdValid, 0);
    chk("R10 dqOut after async reset", 105, dqOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 no slot after reset", 106 + k, rdValid, 0);
    end

    summary();
    $finish;
  end

endmodule